// File: doc/BRIEF.md
# Serial NOR Page-Program Sequencer

This engine writes a stream of bytes into a serial NOR flash through a byte-level SPI master. Software gives it a 24-bit start address, a byte count and the flash page size, then pulses `start`. The engine never lets a program command run past a page boundary. Before each page it sends a write-enable frame. It then opens a program frame with the address and passes stream bytes through. After the frame closes, it reads the status register until the part reports idle. It repeats this until the count is used up, and then pulses `done`.

The master side has a single command channel with a valid/ready handshake. Each command carries an operation and a byte: open a frame (assert chip select), send a byte, receive a byte, or close the frame. A receive is answered later by a one-cycle `rx_valid` strobe that carries the byte read back. Data arrives on a valid/ready stream. While the program frame waits for data, `abort` closes the frame and ends the job.

Top module: `nor_page_writer`

## Requirements
- R1: After reset, `busy`, `done`, `cmd_valid` and `in_ready` are low, and they stay low while the engine is idle.
- R2: A `start` with a byte count of zero issues no command and raises `done` in the cycle after `start` is taken.
- R3: Every program frame is preceded by its own write-enable frame: open (op 0), send byte 0x06 (op 1), close (op 3).
- R4: A program frame is open, send 0x02, then the three address bytes most significant first, then the data bytes in stream order, each sent with op 1.
- R5: The first program frame ends after the byte whose address is one below the smallest multiple of the page size strictly above the start address. Each later frame covers at most one full page. Page size is a power of two from 16 to 4096.
- R6: A frame also ends when the byte count is used up. After the status poll that follows, the engine finishes, having consumed exactly the requested number of stream bytes.
- R7: After each program frame the engine sends open, send 0x05, then receive (op 2) commands. It issues a new receive after each returned byte with bit 0 set, and closes the frame after the first returned byte with bit 0 clear. Other bits of that byte are ignored.
- R8: While a program frame waits for data and `in_valid` is low, no command is issued and the frame stays open. A command that is offered and not yet accepted keeps its op and byte.
- R9: An `abort` while the program frame waits for data yields one close command and then `done`, with no status poll.
- R10: `done` is a one-cycle pulse. `busy` is high from the cycle after `start` is taken through the `done` cycle, and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job (taken when idle) |
| start_addr | input | 24 | First flash byte address |
| byte_count | input | CNT_W | Number of bytes to program |
| page_size | input | PS_W | Flash page size, power of two 16..4096 |
| abort | input | 1 | Stop while waiting for stream data |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted |
| in_data | input | 8 | Stream byte |
| cmd_valid | output | 1 | Command offered to the SPI master |
| cmd_ready | input | 1 | SPI master takes the command |
| cmd_op | output | 2 | 0 open, 1 send, 2 receive, 3 close |
| cmd_byte | output | 8 | Byte for a send command, zero otherwise |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
A command and a stream byte move on the rising edge where both valid and ready are high. The bench drives inputs on the falling edge and samples 8 ns later, 2 ns before the edge that completes the handshake, and scores each accepted command against the next entry in its expected queue. The simulated master returns each status byte two falling edges after a receive command is accepted, as a one-cycle strobe. For a zero count, `done` is due at the first sample after the edge that takes `start`. In every job `busy` must be high from that sample up to and including the `done` sample, and low at the sample after it.

// File: rtl/nor_pw_pkg.sv
package nor_pw_pkg;
  localparam int ADDR_W = 24;

  typedef enum logic [1:0] {
    OP_OPEN  = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_CLOSE = 2'd3
  } spi_op_e;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_PROG = 8'h02;
  localparam logic [7:0] OPC_RDSR = 8'h05;

  typedef enum logic [4:0] {
    S_IDLE,
    S_WE_OPEN,
    S_WE_OP,
    S_WE_CLOSE,
    S_PG_OPEN,
    S_PG_OP,
    S_PG_A2,
    S_PG_A1,
    S_PG_A0,
    S_PG_DATA,
    S_PG_CLOSE,
    S_ST_OPEN,
    S_ST_OP,
    S_ST_RECV,
    S_ST_WAIT,
    S_ST_CLOSE,
    S_AB_CLOSE,
    S_FIN
  } seq_state_e;
endpackage

// File: rtl/nor_pw_rst_sync.sv
module nor_pw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/nor_pw_page_track.sv
module nor_pw_page_track
  import nor_pw_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_count,
  input  logic [PS_W-1:0]   ld_psize,
  input  logic              step,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cnt_zero,
  output logic              frame_last
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] addr_q, addr_d;
  logic [EXT_W-1:0] pend_q, pend_d;
  logic [EXT_W-1:0] psz_q, psz_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] ld_ps_ext, ld_addr_ext;
  logic             upd_en;

  assign ld_ps_ext   = EXT_W'(ld_psize);
  assign ld_addr_ext = {1'b0, ld_addr};
  assign upd_en      = load | step | advance;

  always_comb begin
    addr_d = addr_q;
    pend_d = pend_q;
    psz_d  = psz_q;
    cnt_d  = cnt_q;
    if (load) begin
      addr_d = ld_addr_ext;
      cnt_d  = ld_count;
      psz_d  = ld_ps_ext;
      pend_d = (ld_addr_ext & ~(ld_ps_ext - EXT_W'(1))) + ld_ps_ext;
    end else begin
      if (step) begin
        addr_d = addr_q + EXT_W'(1);
        cnt_d  = cnt_q - CNT_W'(1);
      end
      if (advance) pend_d = pend_q + psz_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pend_q <= '0;
      psz_q  <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      pend_q <= pend_d;
      psz_q  <= psz_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cur_addr   = addr_q[ADDR_W-1:0];
  assign cnt_zero   = (cnt_q == '0);
  assign frame_last = (cnt_q == CNT_W'(1)) || ((addr_q + EXT_W'(1)) == pend_q);
endmodule

// File: rtl/nor_pw_seq.sv
module nor_pw_seq
  import nor_pw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_zero,
  input  logic              abort,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              cmd_valid,
  output spi_op_e           cmd_op,
  output logic [7:0]        cmd_byte,
  input  logic              cmd_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              cnt_zero,
  input  logic              frame_last,
  output logic              load,
  output logic              step,
  output logic              advance,
  output logic              busy,
  output logic              done
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    cmd_valid = 1'b0;
    cmd_op    = OP_OPEN;
    cmd_byte  = 8'h00;
    in_ready  = 1'b0;
    load      = 1'b0;
    step      = 1'b0;
    advance   = 1'b0;
    done      = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          load = 1'b1;
          st_d = start_zero ? S_FIN : S_WE_OPEN;
        end
      end
      S_WE_OPEN: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_OPEN;
        if (cmd_ready) st_d = S_WE_OP;
      end
      S_WE_OP: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_SEND;
        cmd_byte  = OPC_WREN;
        if (cmd_ready) st_d = S_WE_CLOSE;
      end
      S_WE_CLOSE: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_CLOSE;
        if (cmd_ready) st_d = S_PG_OPEN;
      end
      S_PG_OPEN: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_OPEN;
        if (cmd_ready) st_d = S_PG_OP;
      end
      S_PG_OP: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_SEND;
        cmd_byte  = OPC_PROG;
        if (cmd_ready) st_d = S_PG_A2;
      end
      S_PG_A2: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_SEND;
        cmd_byte  = cur_addr[23:16];
        if (cmd_ready) st_d = S_PG_A1;
      end
      S_PG_A1: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_SEND;
        cmd_byte  = cur_addr[15:8];
        if (cmd_ready) st_d = S_PG_A0;
      end
      S_PG_A0: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_SEND;
        cmd_byte  = cur_addr[7:0];
        if (cmd_ready) st_d = S_PG_DATA;
      end
      S_PG_DATA: begin
        if (abort) begin
          st_d = S_AB_CLOSE;
        end else begin
          cmd_valid = in_valid;
          cmd_op    = OP_SEND;
          cmd_byte  = in_data;
          in_ready  = cmd_ready;
          if (in_valid && cmd_ready) begin
            step = 1'b1;
            if (frame_last) st_d = S_PG_CLOSE;
          end
        end
      end
      S_PG_CLOSE: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_CLOSE;
        if (cmd_ready) begin
          advance = 1'b1;
          st_d    = S_ST_OPEN;
        end
      end
      S_ST_OPEN: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_OPEN;
        if (cmd_ready) st_d = S_ST_OP;
      end
      S_ST_OP: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_SEND;
        cmd_byte  = OPC_RDSR;
        if (cmd_ready) st_d = S_ST_RECV;
      end
      S_ST_RECV: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_RECV;
        if (cmd_ready) st_d = S_ST_WAIT;
      end
      S_ST_WAIT: begin
        if (rx_valid) st_d = rx_byte[0] ? S_ST_RECV : S_ST_CLOSE;
      end
      S_ST_CLOSE: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_CLOSE;
        if (cmd_ready) st_d = cnt_zero ? S_FIN : S_WE_OPEN;
      end
      S_AB_CLOSE: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_CLOSE;
        if (cmd_ready) st_d = S_FIN;
      end
      S_FIN: begin
        done = 1'b1;
        st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q != S_IDLE);
endmodule

// File: rtl/nor_page_writer.sv
module nor_page_writer
  import nor_pw_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PS_W      = 13,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [PS_W-1:0]   page_size,
  input  logic              abort,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [7:0]        cmd_byte,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              busy,
  output logic              done
);
  logic              rst_n_sync;
  logic [ADDR_W-1:0] cur_addr;
  logic              cnt_zero;
  logic              frame_last;
  logic              load;
  logic              step;
  logic              advance;
  spi_op_e           op_sel;

  nor_pw_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  nor_pw_page_track #(.CNT_W(CNT_W), .PS_W(PS_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .load       (load),
    .ld_addr    (start_addr),
    .ld_count   (byte_count),
    .ld_psize   (page_size),
    .step       (step),
    .advance    (advance),
    .cur_addr   (cur_addr),
    .cnt_zero   (cnt_zero),
    .frame_last (frame_last)
  );

  nor_pw_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .start      (start),
    .start_zero (byte_count == '0),
    .abort      (abort),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .cmd_valid  (cmd_valid),
    .cmd_op     (op_sel),
    .cmd_byte   (cmd_byte),
    .cmd_ready  (cmd_ready),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .cur_addr   (cur_addr),
    .cnt_zero   (cnt_zero),
    .frame_last (frame_last),
    .load       (load),
    .step       (step),
    .advance    (advance),
    .busy       (busy),
    .done       (done)
  );

  assign cmd_op = op_sel;
endmodule

// File: rtl/nor_page_writer_chk.sv
module nor_page_writer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       abort,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_byte,
  input logic       busy,
  input logic       done
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_valid && !in_ready)) else $error("idle engine active"); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R10

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy) else $error("done outside busy"); // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy) else $error("busy after done"); // R10

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !abort) |=>
      (cmd_valid && $stable(cmd_op) && $stable(cmd_byte))) else $error("offered command changed"); // R8

  AST_DATA_AS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (cmd_valid && cmd_op == 2'd1 && cmd_byte == in_data)) else $error("stream byte not forwarded"); // R4
endmodule

bind nor_page_writer nor_page_writer_chk u_chk (.*);

// File: tb/nor_page_writer_test.sv
module nor_page_writer_test;
  typedef struct {
    logic [1:0] op;
    logic [7:0] b;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [23:0] start_addr;
  logic [15:0] byte_count;
  logic [12:0] page_size;
  logic        abort;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_byte;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        busy;
  logic        done;

  always #10 clk = ~clk;

  nor_page_writer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .page_size(page_size), .abort(abort),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .busy(busy), .done(done)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  exp_t exp_q[$];
  int gap = 1;
  int lim = 0;
  int salt = 0;
  int poll_busy = 0;
  logic [7:0] idle_byte = 8'h00;
  int s_idx = 0;
  bit acc_in = 1'b0;
  int rx_wait = 0;
  int busy_left = 0;
  bit exp_busy = 1'b0;
  bit post_done = 1'b0;
  int done_cnt = 0;

  function automatic logic [7:0] dat(int i);
    return 8'(i * 37 + salt);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(logic [1:0] op, logic [7:0] b, string tag);
    exp_t e;
    e.op = op; e.b = b; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // master model, stream source and scoreboard monitor
  always begin : model
    exp_t e;
    @(negedge clk);
    cyc++;
    if (acc_in) begin
      in_valid = 1'b0;
      s_idx++;
      acc_in = 1'b0;
    end
    if (!in_valid && s_idx < lim && (cyc % gap) == 0) begin
      in_valid = 1'b1;
      in_data  = dat(s_idx);
    end
    rx_valid = 1'b0;
    if (rx_wait > 0) begin
      rx_wait--;
      if (rx_wait == 0) begin
        rx_valid = 1'b1;
        if (busy_left > 0) begin
          rx_byte = 8'h03;
          busy_left--;
        end else begin
          rx_byte = idle_byte;
        end
      end
    end
    cmd_ready = (cyc % 3) != 2;
    #8;
    if (rst_n) begin
      if (cmd_valid && cmd_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected command", {cmd_op, cmd_byte}, 0);
        end else begin
          e = exp_q.pop_front();
          chk(cmd_op == e.op && cmd_byte == e.b, e.tag, "command {op,byte}",
              {cmd_op, cmd_byte}, {e.op, e.b});
        end
        if (cmd_op == 2'd2) rx_wait = 2;
        if (cmd_op == 2'd1 && cmd_byte == 8'h05) busy_left = poll_busy;
      end
      if (in_valid && in_ready) acc_in = 1'b1;
      if (post_done) chk(!busy && !done, "R10", "busy/done after done", {busy, done}, 0);
      if (exp_busy) chk(busy, "R10", "busy during job", busy, 1);
      post_done = done;
      if (done) begin
        chk(busy, "R10", "busy in done cycle", busy, 1);
        done_cnt++;
        exp_busy = 1'b0;
      end else if (start && !busy) begin
        exp_busy = 1'b1;
      end
    end
  end

  task automatic run_job(input int a, input int cnt, input int ps, input int pb,
                         input logic [7:0] ib, input int g, input int limit,
                         input bit do_abort);
    int a_cur, c, pe, n, i, d0, w;
    salt = cnt + a;
    poll_busy = pb;
    idle_byte = ib;
    a_cur = a; c = cnt; i = 0;
    pe = (a / ps + 1) * ps;
    while (c > 0) begin
      push(2'd0, 8'h00, "R3"); push(2'd1, 8'h06, "R3"); push(2'd3, 8'h00, "R3");
      push(2'd0, 8'h00, "R4"); push(2'd1, 8'h02, "R4");
      push(2'd1, 8'(a_cur >> 16), "R4"); push(2'd1, 8'(a_cur >> 8), "R4");
      push(2'd1, 8'(a_cur), "R4");
      n = do_abort ? limit : ((c < pe - a_cur) ? c : pe - a_cur);
      for (int k = 0; k < n; k++) begin
        push(2'd1, dat(i), (g > 1) ? "R8" : "R4");
        i++;
      end
      if (do_abort) begin
        push(2'd3, 8'h00, "R9");
        break;
      end
      push(2'd3, 8'h00, (n == c) ? "R6" : "R5");
      push(2'd0, 8'h00, "R7"); push(2'd1, 8'h05, "R7");
      for (int k = 0; k <= pb; k++) push(2'd2, 8'h00, "R7");
      push(2'd3, 8'h00, "R7");
      a_cur += n; c -= n; pe += ps;
    end
    d0 = done_cnt;
    @(negedge clk);
    s_idx = 0; lim = limit; gap = g;
    start = 1'b1;
    start_addr = 24'(a);
    byte_count = 16'(cnt);
    page_size = 13'(ps);
    @(negedge clk);
    start = 1'b0;
    #8;
    if (cnt == 0) chk(done == 1'b1, "R2", "done one cycle after zero-count start", done, 1);
    else          chk(done == 1'b0, "R10", "no early done", done, 0);
    w = 0;
    if (do_abort) begin
      while (exp_q.size() > 1 && w < 6000) begin @(negedge clk); w++; end
      repeat (4) @(negedge clk);
      chk(busy && !done, "R8", "engine holds frame while stream empty", {busy, done}, 2);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
    end
    while (done_cnt == d0 && w < 6000) begin @(negedge clk); w++; end
    chk(done_cnt == d0 + 1, "R10", "job finished with done", done_cnt - d0, 1);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, do_abort ? "R9" : "R6", "expected commands left over", exp_q.size(), 0);
    chk(s_idx == limit, do_abort ? "R9" : "R6", "stream bytes consumed", s_idx, limit);
    exp_q.delete();
    lim = 0;
  endtask

  initial begin : watchdog
    #(20 * 200000);
    chk(1'b0, "R10", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    rst_n = 1'b0;
    start = 1'b0;
    start_addr = '0;
    byte_count = '0;
    page_size = 13'd16;
    abort = 1'b0;
    in_valid = 1'b0;
    in_data = 8'h00;
    cmd_ready = 1'b0;
    rx_valid = 1'b0;
    rx_byte = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #8;
    // R1: quiet after reset
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(!cmd_valid && !in_ready, "R1", "cmd_valid/in_ready after reset", {cmd_valid, in_ready}, 0);

    // R2: zero count
    run_job(32'h000040, 0, 16, 0, 8'h00, 1, 0, 1'b0);
    // R5: mid-page start, several full pages, short tail
    run_job(32'h00003A, 40, 16, 1, 8'h00, 1, 40, 1'b0);
    // R5/R6: aligned start, exactly one page; R7 idle byte with other bits set
    run_job(32'h000100, 32, 32, 0, 8'h02, 1, 32, 1'b0);
    // R5: top of address space
    run_job(32'hFFFFF8, 8, 16, 2, 8'h00, 1, 8, 1'b0);
    // R5/R7: largest page, long busy poll
    run_job(32'h012FFE, 5, 4096, 3, 8'hFE, 1, 5, 1'b0);
    // R8: slow stream
    run_job(32'h000480, 12, 64, 1, 8'h00, 5, 12, 1'b0);
    // R9: abort while waiting for data
    run_job(32'h000200, 10, 256, 0, 8'h00, 1, 3, 1'b1);

    repeat (4) @(negedge clk);
    #8;
    chk(!busy && !cmd_valid, "R1", "idle after jobs", {busy, cmd_valid}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule